// File: doc/BRIEF.md
# Reset Cause Status Register

This block is a read-only status register. Software reads it to learn why the device last left reset or left its low-power stop mode. It takes a one-cycle pulse from each reset or wake-up source. From these pulses it keeps four latched cause flags. Each source writes its own fixed pattern into all four flags, rather than setting one sticky bit per source. A watchdog timeout writes a different pattern when the part is in stop mode. The lowest bit of the register is not latched. It shows the present level of the low-voltage detector.

The register sits on a simple 8-bit register bus made of an address, a read strobe, a write strobe and a combinational read-data output. The bus has no back-pressure, so every read completes in the cycle it is issued. A read returns the current contents. The four latched flags are then cleared at the next clock edge. Writes have no effect.

Top module: `rstcause_status`

## Requirements
- R1: The read word places the power-on flag in bit 7, the stop-recovery flag in bit 6, the watchdog flag in bit 5 and the external-pin flag in bit 4. Bits 3 to 1 always read 0, and bit 0 is the low-voltage indicator.
- R2: The register drives the read data only when the read strobe is high and the address equals 0xFF0. In every other cycle the read data is 0x00.
- R3: After the block's own reset the flags (power-on, stop, watchdog, external) are 1,0,0,0.
- R4: A power-on event loads 1,0,0,0. A debugger-issued reset loads 1,0,0,1. A stop exit with the debug pin held low loads 1,0,0,0.
- R5: An external reset pin event loads 0,0,0,1. A watchdog timeout while the part is not in stop mode loads 0,0,1,0.
- R6: A stop-mode wake from a GPIO transition loads 0,1,0,0. A watchdog timeout while the part is in stop mode loads 0,1,1,0.
- R7: A read at 0xFF0 returns the current flags and clears all four latched flags to 0 at the next clock edge. A read at any other address clears nothing.
- R8: Bit 0 follows the low-voltage input on every read and is not affected by clear-on-read.
- R9: When several event pulses arrive in the same cycle, only the highest-priority one takes effect. The order from highest to lowest is power-on, debugger reset, debug-pin stop exit, external pin, watchdog, GPIO wake.
- R10: When an event pulse and a read arrive in the same cycle, the read returns the old flags and the event's pattern remains afterwards.
- R11: A write strobe to 0xFF0 leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; loads the power-on pattern |
| bus_addr | input | 12 | Register bus address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe (ignored) |
| bus_rdata | output | 8 | Read data, 0x00 when not selected |
| ev_por | input | 1 | Power-on reset pulse |
| ev_dbg_cmd | input | 1 | Debugger-issued reset pulse |
| ev_dbg_pin | input | 1 | Stop exit with the debug pin low, pulse |
| ev_ext_pin | input | 1 | External reset pin pulse |
| ev_wdt | input | 1 | Watchdog timeout pulse |
| ev_gpio_wake | input | 1 | GPIO stop-mode wake pulse |
| in_stop | input | 1 | High while the part is in stop mode |
| lv_level | input | 1 | Live low-voltage detector level |

## Verification
The bench targets the watchdog split:
- A design that ignores the stop-mode input would report 0,0,1,0 for a wake from stop.
- A design that ORs patterns together would leave stale flags in place.

It also fires several events together. A wrong priority order would leave a lower source's pattern in the register.

The case where a read and an event share a cycle is checked on both sides:
- The old value must come back on the bus.
- The new pattern must still be there on the following read. A design that gives clear-on-read precedence would lose that event.

Finally, the bench checks three things that must not disturb the flags: wrong-address reads, idle cycles and writes. A design whose decode is too loose would clear the flags or return them when it should not.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

  localparam int FLAG_W = 4;
  localparam int NUM_EV = 6;

  // index order is priority order, 0 highest
  typedef enum logic [2:0] {
    CS_POR     = 3'd0,
    CS_DBG_CMD = 3'd1,
    CS_DBG_PIN = 3'd2,
    CS_EXT     = 3'd3,
    CS_WDT     = 3'd4,
    CS_GPIO    = 3'd5
  } cause_e;

  // flag order: {power-on, stop, watchdog, external}
  function automatic logic [FLAG_W-1:0] cause_pattern(input cause_e c, input logic stopped);
    logic [FLAG_W-1:0] p;
    case (c)
      CS_POR:     p = 4'b1000;
      CS_DBG_CMD: p = 4'b1001;
      CS_DBG_PIN: p = 4'b1000;
      CS_EXT:     p = 4'b0001;
      CS_WDT:     p = stopped ? 4'b0110 : 4'b0010;
      CS_GPIO:    p = 4'b0100;
      default:    p = 4'b0000;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/rsc_event_arbiter.sv
module rsc_event_arbiter
  import rsc_pkg::*;
#(
  parameter int N = NUM_EV
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N-1:0]       ev_i,
  input  logic               stopped_i,
  output logic               valid_o,
  output logic [FLAG_W-1:0]  pattern_o
);

  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]     grant;
  logic [IDX_W-1:0] sel_idx;
  logic             found;

  always_comb begin
    grant   = '0;
    sel_idx = '0;
    found   = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (ev_i[i] && !found) begin
        grant[i] = 1'b1;
        sel_idx  = IDX_W'(i);
        found    = 1'b1;
      end
    end
  end

  assign valid_o   = found;
  assign pattern_o = cause_pattern(cause_e'(sel_idx), stopped_i);

  // R9
  grant_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R9
  grant_is_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_i[0] |-> grant[0]);

endmodule

// File: rtl/rsc_flag_store.sv
module rsc_flag_store
  import rsc_pkg::*;
#(
  parameter logic [FLAG_W-1:0] RESET_PAT = 4'b1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [FLAG_W-1:0] load_pat_i,
  input  logic              clr_i,
  output logic [FLAG_W-1:0] flags_o
);

  logic [FLAG_W-1:0] flags_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flags_q <= RESET_PAT;
    else if (load_i) flags_q <= load_pat_i;
    else if (clr_i)  flags_q <= '0;
  end

  assign flags_o = flags_q;

  // R7
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !load_i) |=> (flags_o == '0));

  // R10
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (flags_o == $past(load_pat_i)));

endmodule

// File: rtl/rsc_bus_decode.sv
module rsc_bus_decode
  import rsc_pkg::*;
#(
  parameter int                ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] REG_ADDR = 12'hFF0
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic              lv_i,
  output logic              rd_hit_o,
  output logic [7:0]        rdata_o
);

  localparam int RSV_W = 8 - FLAG_W - 1;

  assign rd_hit_o = rd_i && (addr_i == REG_ADDR);
  assign rdata_o  = rd_hit_o ? {flags_i, {RSV_W{1'b0}}, lv_i} : 8'h00;

endmodule

// File: rtl/rstcause_status.sv
module rstcause_status
  import rsc_pkg::*;
#(
  parameter int                ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] REG_ADDR = 12'hFF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output logic [7:0]        bus_rdata,
  input  logic              ev_por,
  input  logic              ev_dbg_cmd,
  input  logic              ev_dbg_pin,
  input  logic              ev_ext_pin,
  input  logic              ev_wdt,
  input  logic              ev_gpio_wake,
  input  logic              in_stop,
  input  logic              lv_level
);

  logic [NUM_EV-1:0] ev_vec;
  logic              ev_valid;
  logic [FLAG_W-1:0] ev_pat;
  logic [FLAG_W-1:0] flags;
  logic              rd_hit;

  assign ev_vec = {ev_gpio_wake, ev_wdt, ev_ext_pin, ev_dbg_pin, ev_dbg_cmd, ev_por};

  rsc_event_arbiter #(.N(NUM_EV)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_i      (ev_vec),
    .stopped_i (in_stop),
    .valid_o   (ev_valid),
    .pattern_o (ev_pat)
  );

  rsc_flag_store #(.RESET_PAT(4'b1000)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (ev_valid),
    .load_pat_i (ev_pat),
    .clr_i      (rd_hit),
    .flags_o    (flags)
  );

  rsc_bus_decode #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_dec (
    .addr_i   (bus_addr),
    .rd_i     (bus_rd),
    .flags_i  (flags),
    .lv_i     (lv_level),
    .rd_hit_o (rd_hit),
    .rdata_o  (bus_rdata)
  );

  // R4
  por_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_por |=> (flags == 4'b1000));

  // R5
  ext_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ext_pin && !ev_por && !ev_dbg_cmd && !ev_dbg_pin) |=> (flags == 4'b0001));

  // R6
  wdt_stop_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wdt && in_stop && !ev_por && !ev_dbg_cmd && !ev_dbg_pin && !ev_ext_pin)
      |=> (flags == 4'b0110));

  // R11
  write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_rd && !(|ev_vec)) |=> $stable(flags));

  // R2
  idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == 8'h00));

endmodule

// File: tb/tb_rstcause_status.sv
module tb_rstcause_status;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_rdata;
  logic        ev_por = 0, ev_dbg_cmd = 0, ev_dbg_pin = 0, ev_ext_pin = 0;
  logic        ev_wdt = 0, ev_gpio_wake = 0, in_stop = 0, lv_level = 0;

  int checks = 0;
  int failures = 0;

  localparam logic [11:0] REG = 12'hFF0;

  always #2 clk = ~clk;

  rstcause_status dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_rdata(bus_rdata), .ev_por(ev_por), .ev_dbg_cmd(ev_dbg_cmd),
    .ev_dbg_pin(ev_dbg_pin), .ev_ext_pin(ev_ext_pin), .ev_wdt(ev_wdt),
    .ev_gpio_wake(ev_gpio_wake), .in_stop(in_stop), .lv_level(lv_level)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  // mask bits: 0 por,1 dbg_cmd,2 dbg_pin,3 ext,4 wdt,5 gpio
  task automatic set_ev(input logic [5:0] m);
    {ev_gpio_wake, ev_wdt, ev_ext_pin, ev_dbg_pin, ev_dbg_cmd, ev_por} = m;
  endtask

  task automatic pulse(input logic [5:0] m, input logic stop);
    @(negedge clk);
    set_ev(m);
    in_stop = stop;
    @(negedge clk);
    set_ev('0);
    in_stop = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    bus_addr = a;
    bus_rd = 1'b1;
    #1 check(bus_rdata, exp, req);
    @(negedge clk);
    bus_rd = 1'b0;
    bus_addr = '0;
  endtask

  task automatic t_reset();
    rd(REG, 8'h80, "R3 reset pattern");
    rd(REG, 8'h00, "R7 cleared after read");
  endtask

  task automatic t_patterns();
    pulse(6'b000001, 0); rd(REG, 8'h80, "R4 power-on");
    pulse(6'b000010, 0); rd(REG, 8'h90, "R4 debugger reset");
    pulse(6'b000100, 0); rd(REG, 8'h80, "R4 debug pin stop exit");
    pulse(6'b001000, 0); rd(REG, 8'h10, "R5 external pin");
    pulse(6'b010000, 0); rd(REG, 8'h20, "R5 watchdog outside stop");
    pulse(6'b100000, 1); rd(REG, 8'h40, "R6 gpio wake");
    pulse(6'b010000, 1); rd(REG, 8'h60, "R6 watchdog in stop");
    rd(REG, 8'h00, "R7 cleared");
  endtask

  task automatic t_decode();
    pulse(6'b001000, 0);
    rd(12'hFF1, 8'h00, "R2 wrong address");
    rd(12'h7F0, 8'h00, "R2 wrong address high bit");
    @(negedge clk); bus_addr = REG; bus_rd = 1'b0;
    #1 check(bus_rdata, 8'h00, "R2 no strobe");
    @(negedge clk); bus_addr = '0;
    rd(REG, 8'h10, "R7 stray reads clear nothing");
  endtask

  task automatic t_lv();
    lv_level = 1'b1;
    rd(REG, 8'h01, "R8 live level high");
    pulse(6'b000001, 0);
    rd(REG, 8'h81, "R1 layout with lv");
    rd(REG, 8'h01, "R8 lv survives clear");
    lv_level = 1'b0;
    rd(REG, 8'h00, "R8 live level low");
  endtask

  task automatic t_priority();
    pulse(6'b101001, 0); rd(REG, 8'h80, "R9 por over ext and gpio");
    pulse(6'b001010, 0); rd(REG, 8'h90, "R9 debugger over ext");
    pulse(6'b000110, 0); rd(REG, 8'h90, "R9 debugger over debug pin");
    pulse(6'b001100, 0); rd(REG, 8'h80, "R9 debug pin over ext");
    pulse(6'b011000, 1); rd(REG, 8'h10, "R9 ext over watchdog");
    pulse(6'b110000, 1); rd(REG, 8'h60, "R9 watchdog over gpio");
  endtask

  task automatic t_write();
    pulse(6'b010000, 0);
    @(negedge clk); bus_addr = REG; bus_wr = 1'b1;
    #1 check(bus_rdata, 8'h00, "R11 write drives no data");
    @(negedge clk); bus_wr = 1'b0; bus_addr = '0;
    rd(REG, 8'h20, "R11 flags unchanged by write");
  endtask

  task automatic t_collide();
    pulse(6'b100000, 1);
    @(negedge clk);
    bus_addr = REG; bus_rd = 1'b1; set_ev(6'b001000);
    #1 check(bus_rdata, 8'h40, "R10 read returns old");
    @(negedge clk);
    bus_rd = 1'b0; set_ev('0); bus_addr = '0;
    rd(REG, 8'h10, "R10 new event survives read");
    rd(REG, 8'h00, "R7 cleared after collision");
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_patterns();
    t_decode();
    t_lv();
    t_priority();
    t_write();
    t_collide();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule